// File: doc/BRIEF.md
# Shared Global Timer with Banked Compare Channels

This block holds one 64-bit up-counter that several processors share. Each processor has its own compare channel. A channel raises a sticky flag once the counter reaches its 64-bit compare value. It can also drive an interrupt line, and it can move its compare value forward by a fixed step so that it generates a periodic tick. The shared part holds the counter, a run bit and an 8-bit clock divider. The divider slows the count so that the counter advances once every (divider + 1) clock cycles.

All registers are 32 bits wide and sit in a 32-byte window. A processor-select input picks the channel that an access reaches. The counter and the shared control fields are the same for every processor. The compare value, the step, the per-channel enables and the flag belong to the selected channel. Reads are combinational from the address and the processor select. Writes take effect at the clock edge on which the write strobe is high. The word offsets are: 0x00 counter bits 31:0, 0x04 counter bits 63:32, 0x08 control, 0x0C flag, 0x10 compare bits 31:0, 0x14 compare bits 63:32, 0x18 step. Offset 0x1C is unmapped.

Top module: `glb_timer`

## Requirements
- R1: The counter is 64 bits. Offset 0x00 accesses bits 31:0 and offset 0x04 accesses bits 63:32. While the run bit is clear, a write loads the addressed half and the counter then holds its value. A carry out of bit 31 reaches bit 32.
- R2: While the run bit (control bit 0) is set, the counter increments once every (D + 1) cycles, where D is control bits 15:8. The first increment lands on the (D + 1)th clock edge after the edge that writes the run bit.
- R3: A write to either counter half while the run bit is set leaves the counter exactly as if no write had happened.
- R4: A channel's flag is evaluated at each clock edge from the counter and compare values held before that edge. The flag is set when three conditions hold: the shared run bit is set, the channel's compare enable (control bit 1) is set, and the counter is greater than or equal to the compare value. When the counter first equals the compare value, the flag reads 1 one cycle later. No flag is set while the run bit is clear.
- R5: When a channel's flag is being set, its step enable (control bit 3) is set and its step (offset 0x18) is nonzero, the compare value moves up by one step per cycle. It keeps moving until it exceeds the counter, and so settles at the smallest compare + k*step that is greater than the counter. A step of zero leaves the compare value unchanged.
- R6: Each channel's interrupt output equals its flag ANDed with its interrupt enable (control bit 2).
- R7: The flag is read at offset 0x0C, bit 0. Writing 1 to bit 0 clears it. Writing 0 leaves it unchanged.
- R8: After reset, the counter, the shared control, and every channel's control, flag, compare value and step are zero, and all interrupt outputs are low.
- R9: A control write sends bits 0 and 15:8 to the shared register and bits 1 to 3 to the selected processor's channel. A control read returns the shared fields ORed with the selected channel's bits.
- R10: A read of offset 0x1C returns zero. A write to offset 0x1C changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_sel | input | CPU_IDX_W | Processor whose channel an access reaches |
| wr_en | input | 1 | Write strobe for one 32-bit register |
| addr | input | 5 | Byte offset inside the window (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr and cpu_sel |
| irq | output | NUM_CPU | Per-channel interrupt lines |

## Verification
A divider that miscounts shows as a wrong counter value on the first counter read after the expected tick edge. A counter that drops its carry shows on the high-half read right after the low half wraps. A compare value that settles on the wrong multiple shows as soon as the timer is stopped and the compare value is read. A flag or enable held in the wrong channel shows on the interrupt lines within one cycle. The bench samples the flag in the exact cycle before and after it must rise, so a compare stage that is one cycle early or late fails at once.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the global timer.
// Assumes 32-bit register words and a 5-bit byte address.
package tmr_pkg;
    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_CMP_BIT  = 1;
    localparam int CTL_IRQ_BIT  = 2;
    localparam int CTL_STEP_BIT = 3;
    localparam int DIV_LSB      = 8;
    localparam int DIV_W        = 8;
    localparam int WORD_W       = 32;

    typedef enum logic [2:0] {
        WRD_CNT_LO = 3'd0,
        WRD_CNT_HI = 3'd1,
        WRD_CTL    = 3'd2,
        WRD_FLAG   = 3'd3,
        WRD_CMP_LO = 3'd4,
        WRD_CMP_HI = 3'd5,
        WRD_STEP   = 3'd6,
        WRD_HOLE   = 3'd7
    } word_e;

    typedef struct packed {
        logic step_en;
        logic irq_en;
        logic cmp_en;
    } bank_ctl_t;
endpackage

// File: rtl/tmr_count.sv
// Shared up-counter with a programmable divider.
// Assumes CNT_W is two register words wide. Loads are accepted only
// while run is low; the top gates them.
module tmr_count #(
    parameter int CNT_W = 64,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [31:0]      ld_data,
    output logic [CNT_W-1:0] cnt
);
    localparam int HALF = CNT_W / 2;

    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    assign tick = run && (div_cnt == div);

    // Divider phase: restarts whenever the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) div_cnt <= '0;
        else                        div_cnt <= div_cnt + 1'b1;
    end

    // Counter: loads a half while stopped, increments on each divider tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
        else if (ld_lo) cnt[HALF-1:0] <= ld_data[HALF-1:0];
        else if (ld_hi) cnt[CNT_W-1:HALF] <= ld_data[HALF-1:0];
    end
endmodule

// File: rtl/tmr_channel.sv
// One banked compare channel: compare value, step, enables and a sticky flag.
// Compare uses counter >= compare on registered values, so a hit shows
// one cycle after the counter or compare value changes.
module tmr_channel #(
    parameter int CNT_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [CNT_W-1:0]       cnt,
    input  logic                   wr_ctl,
    input  tmr_pkg::bank_ctl_t     ctl_in,
    input  logic                   wr_flag,
    input  logic                   wr_cmp_lo,
    input  logic                   wr_cmp_hi,
    input  logic                   wr_step,
    input  logic [31:0]            wdata,
    output tmr_pkg::bank_ctl_t     ctl_q,
    output logic [CNT_W-1:0]       cmp_q,
    output logic [31:0]            step_q,
    output logic                   flag_q,
    output logic                   irq
);
    localparam int HALF = CNT_W / 2;

    logic hit;
    logic advance;

    assign hit     = run && ctl_q.cmp_en && (cnt >= cmp_q);
    assign advance = hit && ctl_q.step_en && (step_q != '0);
    assign irq     = flag_q && ctl_q.irq_en;

    // Banked enables.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= ctl_in;
    end

    // Step amount.
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= '0;
        else if (wr_step) step_q <= wdata;
    end

    // Compare value: software writes win, otherwise advance one step per hit.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmp_q <= '0;
        else if (wr_cmp_lo) cmp_q[HALF-1:0] <= wdata[HALF-1:0];
        else if (wr_cmp_hi) cmp_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
        else if (advance)   cmp_q <= cmp_q + CNT_W'(step_q);
    end

    // Sticky flag: set by a hit, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit || (flag_q && !(wr_flag && wdata[0]));
    end
endmodule

// File: rtl/tmr_regs.sv
// Register decode and read multiplexer for the global timer.
// Assumes 32-bit accesses only; addr bits 1:0 are ignored.
module tmr_regs #(
    parameter int NUM_CPU   = 2,
    parameter int CPU_IDX_W = 1,
    parameter int CNT_W     = 64
) (
    input  logic                 wr_en,
    input  logic [CPU_IDX_W-1:0] cpu_sel,
    input  logic [4:0]           addr,
    input  logic                 run,
    input  logic [7:0]           div,
    input  logic [CNT_W-1:0]     cnt,
    input  tmr_pkg::bank_ctl_t   ctl_arr  [NUM_CPU],
    input  logic [CNT_W-1:0]     cmp_arr  [NUM_CPU],
    input  logic [31:0]          step_arr [NUM_CPU],
    input  logic [NUM_CPU-1:0]   flag_vec,
    output tmr_pkg::word_e       word,
    output logic [NUM_CPU-1:0]   bank_hit,
    output logic                 shared_ctl_wr,
    output logic                 cnt_wr,
    output logic [31:0]          rdata
);
    import tmr_pkg::*;
    localparam int HALF = CNT_W / 2;

    bank_ctl_t          sel_ctl;
    logic [CNT_W-1:0]   sel_cmp;
    logic [31:0]        sel_step;
    logic               sel_flag;

    assign word          = word_e'(addr[4:2]);
    assign shared_ctl_wr = wr_en && (word == WRD_CTL);
    assign cnt_wr        = wr_en && ((word == WRD_CNT_LO) || (word == WRD_CNT_HI));

    // Pick the banked state of the selected processor.
    always_comb begin
        bank_hit = '0;
        sel_ctl  = '0;
        sel_cmp  = '0;
        sel_step = '0;
        sel_flag = 1'b0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu_sel == CPU_IDX_W'(i)) begin
                bank_hit[i] = 1'b1;
                sel_ctl     = ctl_arr[i];
                sel_cmp     = cmp_arr[i];
                sel_step    = step_arr[i];
                sel_flag    = flag_vec[i];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        unique case (word)
            WRD_CNT_LO: rdata = cnt[HALF-1:0];
            WRD_CNT_HI: rdata = cnt[CNT_W-1:HALF];
            WRD_CTL: begin
                rdata[CTL_RUN_BIT]               = run;
                rdata[CTL_CMP_BIT]               = sel_ctl.cmp_en;
                rdata[CTL_IRQ_BIT]               = sel_ctl.irq_en;
                rdata[CTL_STEP_BIT]              = sel_ctl.step_en;
                rdata[DIV_LSB +: DIV_W]          = div;
            end
            WRD_FLAG:   rdata[0] = sel_flag;
            WRD_CMP_LO: rdata = sel_cmp[HALF-1:0];
            WRD_CMP_HI: rdata = sel_cmp[CNT_W-1:HALF];
            WRD_STEP:   rdata = sel_step;
            WRD_HOLE:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/glb_timer.sv
// Global timer top: shared counter and control, one compare channel per
// processor. Assumes NUM_CPU >= 1 and a 64-bit counter.
module glb_timer #(
    parameter int NUM_CPU   = 2,
    parameter int CNT_W     = 64,
    parameter int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_IDX_W-1:0] cpu_sel,
    input  logic                 wr_en,
    input  logic [4:0]           addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [NUM_CPU-1:0]   irq
);
    import tmr_pkg::*;

    logic               run_q;
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   cnt_q;
    word_e              word;
    logic [NUM_CPU-1:0] bank_hit;
    logic               shared_ctl_wr;
    logic               cnt_wr;
    logic [NUM_CPU-1:0] flag_vec;
    bank_ctl_t          ctl_arr  [NUM_CPU];
    logic [CNT_W-1:0]   cmp_arr  [NUM_CPU];
    logic [31:0]        step_arr [NUM_CPU];
    bank_ctl_t          ctl_wr_val;

    assign ctl_wr_val.cmp_en  = wdata[CTL_CMP_BIT];
    assign ctl_wr_val.irq_en  = wdata[CTL_IRQ_BIT];
    assign ctl_wr_val.step_en = wdata[CTL_STEP_BIT];

    // Shared control: run bit and divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= '0;
        end else if (shared_ctl_wr) begin
            run_q <= wdata[CTL_RUN_BIT];
            div_q <= wdata[DIV_LSB +: DIV_W];
        end
    end

    tmr_regs #(
        .NUM_CPU(NUM_CPU), .CPU_IDX_W(CPU_IDX_W), .CNT_W(CNT_W)
    ) u_regs (
        .wr_en(wr_en), .cpu_sel(cpu_sel), .addr(addr),
        .run(run_q), .div(div_q), .cnt(cnt_q),
        .ctl_arr(ctl_arr), .cmp_arr(cmp_arr), .step_arr(step_arr),
        .flag_vec(flag_vec), .word(word), .bank_hit(bank_hit),
        .shared_ctl_wr(shared_ctl_wr), .cnt_wr(cnt_wr), .rdata(rdata)
    );

    tmr_count #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run_q), .div(div_q),
        .ld_lo(cnt_wr && !run_q && (word == WRD_CNT_LO)),
        .ld_hi(cnt_wr && !run_q && (word == WRD_CNT_HI)),
        .ld_data(wdata), .cnt(cnt_q)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chan
        logic bwr;
        assign bwr = wr_en && bank_hit[g];
        tmr_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt_q),
            .wr_ctl(bwr && (word == WRD_CTL)), .ctl_in(ctl_wr_val),
            .wr_flag(bwr && (word == WRD_FLAG)),
            .wr_cmp_lo(bwr && (word == WRD_CMP_LO)),
            .wr_cmp_hi(bwr && (word == WRD_CMP_HI)),
            .wr_step(bwr && (word == WRD_STEP)),
            .wdata(wdata), .ctl_q(ctl_arr[g]), .cmp_q(cmp_arr[g]),
            .step_q(step_arr[g]), .flag_q(flag_vec[g]), .irq(irq[g])
        );
    end
endmodule

// File: rtl/glb_timer_chk.sv
// Assertion checker for glb_timer, attached by bind below.
module glb_timer_chk #(
    parameter int NUM_CPU = 2,
    parameter int CNT_W   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               cnt_wr,
    input logic [CNT_W-1:0]   cnt,
    input logic [NUM_CPU-1:0] flags,
    input logic [NUM_CPU-1:0] irq
);
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(cnt_wr)) |-> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));

    // R3
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(cnt_wr)) |-> ((cnt - $past(cnt)) <= CNT_W'(1)));

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_ch
        // R6
        irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> flags[g]);

        // R4
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[g]) |-> $past(run));
    end
endmodule

bind glb_timer glb_timer_chk #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cnt_wr(cnt_wr),
    .cnt(cnt_q), .flags(flag_vec), .irq(irq)
);

// File: tb/glb_timer_test.sv
// Scoreboard bench: driver tasks queue expected read results, a monitor
// samples at the falling edge and compares.
module glb_timer_test;
    localparam int NCPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  cpu_sel = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCPU-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0]     exp;
        logic            chk_irq;
        logic [NCPU-1:0] exp_irq;
        string           tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    glb_timer #(.NUM_CPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic wr(input int cpu, input logic [4:0] a, input logic [31:0] d);
        cpu_sel = cpu[0:0]; addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [4:0] a, input logic [31:0] e,
                      input logic ci, input logic [NCPU-1:0] ei, input string tag);
        item_t it;
        cpu_sel = cpu[0:0]; addr = a;
        it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare queued expectations mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s rdata got %h exp %h", it.tag, rdata, it.exp);
                end
                if (it.chk_irq) begin
                    n_tests++;
                    if (irq !== it.exp_irq) begin
                        n_fail++;
                        $display("FAIL %s irq got %b exp %b", it.tag, irq, it.exp_irq);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: everything zero after reset
        for (int w = 0; w < 7; w++) rd(0, 5'(w * 4), 32'h0, 1'b1, 2'b00, "R8");
        rd(1, 5'h10, 32'h0, 1'b0, 2'b00, "R8");
        rd(1, 5'h08, 32'h0, 1'b0, 2'b00, "R8");

        // R1: load both halves while stopped
        wr(0, 5'h00, 32'hFFFF_FFF0);
        wr(0, 5'h04, 32'h0000_0001);
        rd(1, 5'h00, 32'hFFFF_FFF0, 1'b0, 2'b00, "R1");
        rd(0, 5'h04, 32'h0000_0001, 1'b0, 2'b00, "R1");
        idle(3);
        rd(0, 5'h00, 32'hFFFF_FFF0, 1'b0, 2'b00, "R1");

        // R2: divider 3, increment every 4th edge
        wr(0, 5'h08, 32'h0000_0301);
        rd(0, 5'h00, 32'hFFFF_FFF0, 1'b0, 2'b00, "R2");
        idle(2);
        rd(0, 5'h00, 32'hFFFF_FFF0, 1'b0, 2'b00, "R2");
        rd(0, 5'h00, 32'hFFFF_FFF1, 1'b0, 2'b00, "R2");
        idle(58);
        wr(0, 5'h08, 32'h0);
        rd(0, 5'h00, 32'h0000_0000, 1'b0, 2'b00, "R2");
        rd(0, 5'h04, 32'h0000_0002, 1'b0, 2'b00, "R1");

        // R3: counter write ignored while running
        wr(0, 5'h08, 32'h0000_0001);
        wr(0, 5'h00, 32'h0000_1234);
        wr(0, 5'h08, 32'h0);
        rd(0, 5'h00, 32'h0000_0002, 1'b0, 2'b00, "R3");
        rd(0, 5'h04, 32'h0000_0002, 1'b0, 2'b00, "R3");

        // R4 and R6: compare on channel 0
        wr(0, 5'h10, 32'h0000_0010);
        wr(0, 5'h14, 32'h0000_0002);
        wr(0, 5'h08, 32'h0000_0007);
        idle(13);
        rd(0, 5'h0C, 32'h0, 1'b1, 2'b00, "R4");
        rd(0, 5'h0C, 32'h0, 1'b1, 2'b00, "R4");
        rd(0, 5'h0C, 32'h1, 1'b1, 2'b01, "R4");
        rd(1, 5'h0C, 32'h0, 1'b1, 2'b01, "R6");

        // R7: write-one-to-clear with the timer stopped
        wr(0, 5'h08, 32'h0000_0006);
        wr(0, 5'h0C, 32'h0);
        rd(0, 5'h0C, 32'h1, 1'b1, 2'b01, "R7");
        wr(0, 5'h0C, 32'h1);
        rd(0, 5'h0C, 32'h0, 1'b1, 2'b00, "R7");
        idle(3);
        rd(0, 5'h0C, 32'h0, 1'b1, 2'b00, "R4");

        // R9: split control register
        wr(1, 5'h08, 32'h0000_0A00);
        rd(0, 5'h08, 32'h0000_0A06, 1'b0, 2'b00, "R9");
        rd(1, 5'h08, 32'h0000_0A00, 1'b0, 2'b00, "R9");

        // R5: periodic stepping on channel 1
        wr(1, 5'h00, 32'h0);
        wr(1, 5'h04, 32'h0);
        wr(1, 5'h10, 32'h0000_0005);
        wr(1, 5'h14, 32'h0);
        wr(1, 5'h18, 32'h0000_0003);
        wr(1, 5'h08, 32'h0000_000F);
        idle(19);
        wr(1, 5'h08, 32'h0000_000E);
        rd(1, 5'h10, 32'd20, 1'b1, 2'b10, "R5");
        rd(1, 5'h00, 32'd20, 1'b0, 2'b00, "R2");

        // R5: catch-up to the smallest multiple past the counter
        wr(1, 5'h10, 32'h0000_0002);
        wr(1, 5'h18, 32'h0000_0007);
        wr(1, 5'h08, 32'h0000_FF0F);
        idle(8);
        wr(1, 5'h08, 32'h0000_000E);
        rd(1, 5'h10, 32'd23, 1'b0, 2'b00, "R5");
        rd(1, 5'h00, 32'd20, 1'b0, 2'b00, "R5");

        // R5: zero step leaves the compare value alone
        wr(1, 5'h0C, 32'h1);
        wr(1, 5'h10, 32'h0000_0004);
        wr(1, 5'h18, 32'h0);
        wr(1, 5'h08, 32'h0000_FF0F);
        idle(4);
        wr(1, 5'h08, 32'h0000_000E);
        rd(1, 5'h10, 32'd4, 1'b0, 2'b00, "R5");
        rd(1, 5'h0C, 32'h1, 1'b1, 2'b10, "R4");

        // R6: interrupt enable gates the line
        wr(1, 5'h08, 32'h0000_000A);
        rd(1, 5'h0C, 32'h1, 1'b1, 2'b00, "R6");

        // R10: unmapped offset
        wr(1, 5'h1C, 32'hFFFF_FFFF);
        rd(1, 5'h1C, 32'h0, 1'b0, 2'b00, "R10");
        rd(1, 5'h10, 32'd4, 1'b0, 2'b00, "R10");
        rd(1, 5'h18, 32'h0, 1'b0, 2'b00, "R10");
        rd(1, 5'h00, 32'd20, 1'b0, 2'b00, "R10");
        rd(0, 5'h18, 32'h0, 1'b0, 2'b00, "R10");

        wait (sb_q.size() == 0);
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule